// File: doc/BRIEF.md
# Phase-Staggered Down-Counter PWM Array

This block drives a bank of 8-bit pulse-width outputs, such as the colour channels of an LED display. Each channel owns one loadable down-counter. The block keeps no shared comparator and no array of stored duty values that is scanned against a common ramp. A free-running frame position advances once per clock enable, and one frame is 256 enables long. Every channel begins its own cycle at a fixed offset inside the frame. The offsets are spread evenly, so that cycle starts fall one channel at a time.

Because the starts are staggered, an external controller needs to service only one channel at a time. The block announces, one enable in advance, which channel starts next. The controller answers by driving the width for that channel on a shared 8-bit bus, with a channel index and a write strobe. If a channel receives no new width, it repeats the last one it was given.

Top module: `pwm_stagger_array`

## Requirements
- R1: While `rst` is high and after it is released, every `pwm_out` bit is 0, `req_vld` is 0, every stored width is 0, and the frame position is 0.
- R2: One frame is 256 enables. Channel k starts its cycle on the enable taken while the frame position equals k*(256/NUM_CH). Adjacent channels therefore start 256/NUM_CH enables apart, which is 8 for the default of 32 channels.
- R3: While `tick_en` is low, the frame position, every counter, every `pwm_out` bit and the request outputs hold their values.
- R4: At its cycle start, a channel with stored width W (nonzero) drives its output high for exactly W enables, counted from that start, and low for the rest of the cycle.
- R5: A width of 0 keeps the output low for the whole 256-enable cycle. A width of 255 keeps it high for 255 of the 256 enables.
- R6: A clock with `ld_stb` high stores `ld_val` as the width of channel `ld_ch`. A width stored in the middle of a channel's cycle does not change the pulse in progress; it takes effect at that channel's next start.
- R7: A channel that gets no new width before its cycle start repeats its previous width.
- R8: `req_vld` is high, and `req_ch` holds channel k, during the single enable slot immediately before channel k's start. Requests arrive in ascending channel order, NUM_CH per frame, and the request for channel 0 occupies the last slot of the frame.
- R9: A width written in the same clock as that channel's start enable is the width used for the cycle that begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable that advances the frame by one slot |
| ld_stb | input | 1 | Width write strobe |
| ld_ch | input | $clog2(NUM_CH) | Channel addressed by the write |
| ld_val | input | 8 | Pulse width to store |
| req_vld | output | 1 | A channel starts on the next enable |
| req_ch | output | $clog2(NUM_CH) | Index of the channel that starts next |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
Two functions can fall in the same clock: a write of a new width into a channel, and that channel's own cycle start, which captures the width into the counter. The bench provokes this by waiting for the request for a channel, letting the slot pass without a write, and then strobing a fresh width on the very clock of the start enable. It judges the outcome by counting the high enables of the cycle that follows, and expects the fresh value rather than the older stored one. A related case writes a new width in the middle of a running pulse. That cycle must keep its old length, and the next cycle must take the new width.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;

    localparam int CNT_W = 8;
    localparam int FRAME = 1 << CNT_W;

    typedef logic [CNT_W-1:0] width_t;

    // per-channel register set
    typedef struct packed {
        width_t width;
        width_t cnt;
        logic   out;
    } chan_regs_t;

    // write request as seen by a single channel
    typedef struct packed {
        logic   hit;
        width_t val;
    } chan_wr_t;

    function automatic width_t start_slot(input int k, input int n);
        return width_t'(k * (FRAME / n));
    endfunction

endpackage

// File: rtl/pwm_frame_timer.sv
module pwm_frame_timer
    import pwm_stagger_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    output logic [NUM_CH-1:0] hit_vec,
    output logic              req_vld,
    output logic [IDX_W-1:0]  req_ch
);

    width_t pos_q;
    width_t pos_nx;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (tick_en)
            pos_q <= width_t'(pos_q + 1'b1);
    end

    assign pos_nx = width_t'(pos_q + 1'b1);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_hit
        assign hit_vec[k] = (pos_q == start_slot(k, NUM_CH));
    end

    always_comb begin
        req_vld = 1'b0;
        req_ch  = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (pos_nx == start_slot(k, NUM_CH)) begin
                req_vld = 1'b1;
                req_ch  = IDX_W'(k);
            end
        end
    end

    // R2: at most one channel owns any slot
    p_single_start_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R3: no enable, no movement
    p_pos_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(pos_q));

    // R8: an announced channel owns the following slot
    p_req_precedes_start_r8: assert property (@(posedge clk) disable iff (rst)
        (req_vld && tick_en) |=> hit_vec[$past(req_ch)]);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_stagger_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  logic     start_hit,
    input  chan_wr_t wr,
    output logic     pwm
);

    chan_regs_t r_q;
    width_t     eff_width;
    logic       go;

    // a write in the start clock is forwarded to the counter
    assign eff_width = wr.hit ? wr.val : r_q.width;
    assign go        = tick_en && start_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            if (wr.hit)
                r_q.width <= wr.val;
            if (go) begin
                r_q.cnt <= eff_width;
                r_q.out <= (eff_width != '0);
            end else if (tick_en && r_q.cnt != '0) begin
                r_q.cnt <= width_t'(r_q.cnt - 1'b1);
                r_q.out <= (r_q.cnt != width_t'(1));
            end
        end
    end

    assign pwm = r_q.out;

    // R4: a pulse can only begin on this channel's start enable
    p_rise_at_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.out) |-> $past(go));

    // R4: a high output always has count left
    p_out_needs_count_r4: assert property (@(posedge clk) disable iff (rst)
        r_q.out |-> (r_q.cnt != '0));

    // R5: an exhausted counter stays idle until the next start
    p_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !start_hit && r_q.cnt == '0) |=> (!r_q.out && r_q.cnt == '0));

    // R3: stall freezes the counter and the output
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(r_q.cnt) && $stable(r_q.out)));

endmodule

// File: rtl/pwm_stagger_array.sv
module pwm_stagger_array
    import pwm_stagger_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              ld_stb,
    input  logic [IDX_W-1:0]  ld_ch,
    input  logic [CNT_W-1:0]  ld_val,
    output logic              req_vld,
    output logic [IDX_W-1:0]  req_ch,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0] hit_vec;

    pwm_frame_timer #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .hit_vec (hit_vec),
        .req_vld (req_vld),
        .req_ch  (req_ch)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        chan_wr_t wr_k;

        assign wr_k.hit = ld_stb && (ld_ch == IDX_W'(k));
        assign wr_k.val = ld_val;

        pwm_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick_en   (tick_en),
            .start_hit (hit_vec[k]),
            .wr        (wr_k),
            .pwm       (pwm_out[k])
        );
    end

    // R1: outputs are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0));

endmodule

// File: tb/tb_pwm_stagger_array.sv
module tb_pwm_stagger_array;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 32;
    localparam int IW         = $clog2(NCH);
    localparam int NVEC       = 8;

    // {channel[4:0], width[7:0]}; expected high count equals the width
    localparam logic [12:0] VECS [NVEC] = '{
        {5'd0,  8'd1},
        {5'd31, 8'd255},
        {5'd7,  8'd0},
        {5'd12, 8'd128},
        {5'd3,  8'd200},
        {5'd20, 8'd17},
        {5'd31, 8'd2},
        {5'd0,  8'd254}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick_en = 1'b1;
    logic           ld_stb = 1'b0;
    logic [IW-1:0]  ld_ch = '0;
    logic [7:0]     ld_val = '0;
    logic           req_vld;
    logic [IW-1:0]  req_ch;
    logic [NCH-1:0] pwm_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_stagger_array #(.NUM_CH(NCH)) dut (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ld_stb  (ld_stb),
        .ld_ch   (ld_ch),
        .ld_val  (ld_val),
        .req_vld (req_vld),
        .req_ch  (req_ch),
        .pwm_out (pwm_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(input int ch);
        for (int i = 0; i < 300; i++) begin
            if (req_vld && req_ch == IW'(ch)) return;
            step();
        end
        check(1'b0, "R8 request never seen", 0, ch);
    endtask

    // write during the request slot; returns at the slot of the start
    task automatic load_at_req(input int ch, input int val);
        wait_req(ch);
        ld_stb = 1'b1; ld_ch = IW'(ch); ld_val = 8'(val);
        step();
        ld_stb = 1'b0;
    endtask

    // entered just after the start enable; samples one full cycle
    task automatic measure(input int ch, output int cnt, output bit first);
        cnt = 0;
        first = pwm_out[ch];
        for (int i = 0; i < 256; i++) begin
            if (pwm_out[ch]) cnt++;
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  c;
        bit  f;
        step(); step();
        // R1: reset state
        check(pwm_out == '0, "R1 outputs low in reset", int'(pwm_out != '0), 0);
        check(req_vld == 1'b0, "R1 no request in reset", int'(req_vld), 0);
        rst = 1'b0;
        step();
        check(pwm_out == '0, "R1 outputs low after reset", int'(pwm_out != '0), 0);
        check(req_vld == 1'b0, "R1 no request after reset", int'(req_vld), 0);

        // vector table: R4, R5, R7
        for (int v = 0; v < NVEC; v++) begin
            int ch;
            int w;
            ch = int'(VECS[v][12:8]);
            w  = int'(VECS[v][7:0]);
            load_at_req(ch, w);
            step();
            measure(ch, c, f);
            check(c == w, "R4/R5 high enables in cycle", c, w);
            check(f == (w != 0), "R4 level right after start", int'(f), int'(w != 0));
            measure(ch, c, f);
            check(c == w, "R7 width reused with no write", c, w);
        end

        // R8: request order over one frame
        begin
            int seen;
            int prev;
            seen = 0;
            prev = 0;
            for (int i = 0; i < 256; i++) begin
                if (req_vld) begin
                    if (seen > 0)
                        check(int'(req_ch) == ((prev + 1) % NCH), "R8 ascending request order",
                              int'(req_ch), (prev + 1) % NCH);
                    prev = int'(req_ch);
                    seen++;
                end
                step();
            end
            check(seen == NCH, "R8 requests per frame", seen, NCH);
        end

        // R9: write on the start clock is used at once
        load_at_req(6, 40);
        wait_req(6);
        step();
        ld_stb = 1'b1; ld_ch = IW'(6); ld_val = 8'd77;
        step();
        ld_stb = 1'b0;
        measure(6, c, f);
        check(c == 77, "R9 write in start clock wins", c, 77);

        // R6: mid-cycle write leaves running pulse alone
        load_at_req(10, 90);
        step();
        c = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_out[10]) c++;
            if (i == 20) begin ld_stb = 1'b1; ld_ch = IW'(10); ld_val = 8'd30; end
            step();
            ld_stb = 1'b0;
        end
        check(c == 90, "R6 running pulse unchanged", c, 90);
        measure(10, c, f);
        check(c == 30, "R6 new width at next start", c, 30);

        // R2: adjacent channels start 8 enables apart
        load_at_req(4, 200);
        load_at_req(5, 200);
        wait_req(4);
        step(); step();
        begin
            int rise_at;
            bit prev_lvl;
            rise_at = -1;
            prev_lvl = pwm_out[5];
            for (int i = 0; i < 20; i++) begin
                if (pwm_out[5] && !prev_lvl && rise_at < 0) rise_at = i;
                prev_lvl = pwm_out[5];
                step();
            end
            check(rise_at == 8, "R2 stagger between channels", rise_at, 8);
        end

        // R3: stall holds everything
        load_at_req(9, 100);
        step(); step(); step();
        begin
            logic [NCH-1:0] snap_out;
            logic           snap_v;
            logic [IW-1:0]  snap_c;
            tick_en = 1'b0;
            snap_out = pwm_out; snap_v = req_vld; snap_c = req_ch;
            for (int i = 0; i < 5; i++) step();
            check(pwm_out == snap_out, "R3 outputs held in stall", int'(pwm_out[9]), int'(snap_out[9]));
            check(req_vld == snap_v && req_ch == snap_c, "R3 request held in stall",
                  int'(req_ch), int'(snap_c));
            tick_en = 1'b1;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule